// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Arbiter

This block picks one interrupt at a time for a processor core from a set of maskable request lines, a non-maskable request and an address-trap request. Every maskable source carries a stored enable bit and a stored level bit that puts it in level 0 or level 1. Two processor mask bits, called I and UI here, combine into three masking states. With I clear, everything is open. With I set and UI clear, only level-1 sources, the non-maskable request and the trap get through. With both set, only the non-maskable request and the trap get through.

Each cycle the block filters the pending requests through the enables and masks and ranks the survivors. It registers the winner as an interrupt number with a valid strobe. While that strobe waits for acknowledge, the presented number changes only when a strictly higher-ranked request appears. An acknowledge takes the interrupt and sets both mask bits, as exception entry does. Software can also load both mask bits directly through a write port.

Top module: `irq_mask_arbiter`

## Requirements
- R1: After reset, I and UI read 1, irq_valid is 0, and every stored enable and level bit is 0. As a result, no maskable source can win until the configuration is written.
- R2: A source whose level bit is 0 can win only while I is 0. UI has no effect on it.
- R3: A source whose level bit is 1 can win while I is 0 or UI is 0. It is masked only when both are 1.
- R4: A maskable source competes only while its stored enable bit is 1.
- R5: The non-maskable request wins whatever the mask bits and other requests are. The address trap wins over every maskable source whatever the mask bits are.
- R6: Every open level-1 source outranks every open level-0 source. Within one level, the lower source index wins.
- R7: When ack is high while irq_valid is 1, the next cycle shows I=1, UI=1 and irq_valid=0. This takes precedence over a mask write in the same cycle. When ack is high while irq_valid is 0, it has no effect.
- R8: When mask_we is high and no acknowledge is taken, I and UI take i_wdata and ui_wdata on the next cycle.
- R9: While irq_valid is 1 and no ack is given, the next cycle keeps irq_valid at 1. It keeps the same irq_id, even if the request is withdrawn, unless a strictly higher-ranked request is pending.
- R10: irq_valid and irq_id reflect the requests, configuration and mask bits of the previous cycle. irq_id is 0 for the non-maskable request, 1 for the address trap and 2+k for maskable source k.
- R11: When cfg_we is high, en_in and lvl_in are stored as the enable and level bits. They take effect in the arbitration of the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_SRC | Maskable request lines, level sensitive |
| nmi | input | 1 | Non-maskable request |
| addr_trap | input | 1 | Address-trap request |
| cfg_we | input | 1 | Load strobe for enable and level bits |
| en_in | input | N_SRC | Enable bits to store |
| lvl_in | input | N_SRC | Level bits to store (1 = level 1) |
| mask_we | input | 1 | Direct write strobe for I and UI |
| i_wdata | input | 1 | Value written to I |
| ui_wdata | input | 1 | Value written to UI |
| ack | input | 1 | Processor takes the presented interrupt |
| irq_valid | output | 1 | An interrupt is being presented |
| irq_id | output | ID_W | Presented interrupt number |
| i_mask | output | 1 | Current I bit |
| ui_mask | output | 1 | Current UI bit |

## Verification
Suppose a mask bit or a stored level bit holds the wrong value. Then a source that should be blocked appears on irq_valid one cycle after it is raised, or a source that should win never appears. A wrong latch of the presented number shows as irq_id moving while the strobe waits for acknowledge. A lost acknowledge shows as the mask bits staying open on the cycle right after ack. The scenarios place single sources at each level under each of the three masking states, so a swapped mask term surfaces within two cycles of the configuration that exposes it.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int ID_NMI      = 0;
  localparam int ID_TRAP     = 1;
  localparam int ID_SRC_BASE = 2;

  // Whether a maskable source of the given level passes the mask bits.
  function automatic logic level_open(input logic lvl1, input logic i_bit,
                                      input logic ui_bit);
    if (lvl1) return !(i_bit && ui_bit);
    return !i_bit;
  endfunction

  // Rank of a maskable source: smaller is more urgent.
  function automatic int src_rank(input int idx, input logic lvl1, input int nsrc);
    if (lvl1) return ID_SRC_BASE + idx;
    return ID_SRC_BASE + nsrc + idx;
  endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [N_SRC-1:0] en_in,
  input  logic [N_SRC-1:0] lvl_in,
  output logic [N_SRC-1:0] en_q,
  output logic [N_SRC-1:0] lvl_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      lvl_q <= '0;
    end else if (cfg_we) begin
      en_q  <= en_in;
      lvl_q <= lvl_in;
    end
  end

endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_take,
  input  logic mask_we,
  input  logic i_wdata,
  input  logic ui_wdata,
  output logic i_q,
  output logic ui_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      i_q  <= 1'b1;
      ui_q <= 1'b1;
    end else if (ack_take) begin
      i_q  <= 1'b1;
      ui_q <= 1'b1;
    end else if (mask_we) begin
      i_q  <= i_wdata;
      ui_q <= ui_wdata;
    end
  end

endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
  import irq_arb_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int ID_W   = 4,
  parameter int RANK_W = 5
) (
  input  logic [N_SRC-1:0]  req,
  input  logic [N_SRC-1:0]  en_q,
  input  logic [N_SRC-1:0]  lvl_q,
  input  logic              i_q,
  input  logic              ui_q,
  input  logic              nmi,
  input  logic              addr_trap,
  output logic              cand_valid,
  output logic [ID_W-1:0]   cand_id,
  output logic [RANK_W-1:0] cand_rank,
  output logic              sel_nmi,
  output logic              sel_trap,
  output logic              sel_lvl1,
  output logic              sel_lvl0
);

  logic [N_SRC-1:0] open_v;
  logic [N_SRC-1:0] hi_v;
  logic [N_SRC-1:0] lo_v;

  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    assign open_v[k] = req[k] && en_q[k] && level_open(lvl_q[k], i_q, ui_q);
    assign hi_v[k]   = open_v[k] && lvl_q[k];
    assign lo_v[k]   = open_v[k] && !lvl_q[k];
  end

  logic hi_hit, lo_hit;
  int   hi_idx, lo_idx;

  always_comb begin
    hi_hit = 1'b0;
    lo_hit = 1'b0;
    hi_idx = 0;
    lo_idx = 0;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (hi_v[k]) begin
        hi_hit = 1'b1;
        hi_idx = k;
      end
      if (lo_v[k]) begin
        lo_hit = 1'b1;
        lo_idx = k;
      end
    end
  end

  always_comb begin
    sel_nmi   = nmi;
    sel_trap  = !nmi && addr_trap;
    sel_lvl1  = !nmi && !addr_trap && hi_hit;
    sel_lvl0  = !nmi && !addr_trap && !hi_hit && lo_hit;
    cand_valid = sel_nmi || sel_trap || sel_lvl1 || sel_lvl0;
    cand_id   = '0;
    cand_rank = '1;
    if (sel_nmi) begin
      cand_id   = ID_W'(ID_NMI);
      cand_rank = RANK_W'(ID_NMI);
    end else if (sel_trap) begin
      cand_id   = ID_W'(ID_TRAP);
      cand_rank = RANK_W'(ID_TRAP);
    end else if (sel_lvl1) begin
      cand_id   = ID_W'(ID_SRC_BASE + hi_idx);
      cand_rank = RANK_W'(src_rank(hi_idx, 1'b1, N_SRC));
    end else if (sel_lvl0) begin
      cand_id   = ID_W'(ID_SRC_BASE + lo_idx);
      cand_rank = RANK_W'(src_rank(lo_idx, 1'b0, N_SRC));
    end
  end

endmodule

// File: rtl/irq_present.sv
module irq_present #(
  parameter int ID_W   = 4,
  parameter int RANK_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_take,
  input  logic              cand_valid,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [RANK_W-1:0] cand_rank,
  output logic              valid_q,
  output logic [ID_W-1:0]   id_q,
  output logic [RANK_W-1:0] rank_q
);

  logic preempt;
  assign preempt = cand_valid && (cand_rank < rank_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      id_q    <= '0;
      rank_q  <= '1;
    end else if (ack_take) begin
      valid_q <= 1'b0;
      rank_q  <= '1;
    end else if (!valid_q) begin
      valid_q <= cand_valid;
      id_q    <= cand_id;
      rank_q  <= cand_valid ? cand_rank : '1;
    end else if (preempt) begin
      id_q   <= cand_id;
      rank_q <= cand_rank;
    end
  end

endmodule

// File: rtl/irq_mask_arbiter.sv
module irq_mask_arbiter #(
  parameter int N_SRC  = 8,
  parameter int ID_W   = $clog2(N_SRC + 2),
  parameter int RANK_W = $clog2(2 * N_SRC + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req,
  input  logic             nmi,
  input  logic             addr_trap,
  input  logic             cfg_we,
  input  logic [N_SRC-1:0] en_in,
  input  logic [N_SRC-1:0] lvl_in,
  input  logic             mask_we,
  input  logic             i_wdata,
  input  logic             ui_wdata,
  input  logic             ack,
  output logic             irq_valid,
  output logic [ID_W-1:0]  irq_id,
  output logic             i_mask,
  output logic             ui_mask
);

  logic [N_SRC-1:0]  en_q, lvl_q;
  logic              ack_take;
  logic              cand_valid;
  logic [ID_W-1:0]   cand_id;
  logic [RANK_W-1:0] cand_rank;
  logic [RANK_W-1:0] held_rank;
  logic              sel_nmi, sel_trap, sel_lvl1, sel_lvl0;

  assign ack_take = ack && irq_valid;

  irq_cfg_regs #(.N_SRC(N_SRC)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .en_in(en_in), .lvl_in(lvl_in), .en_q(en_q), .lvl_q(lvl_q)
  );

  irq_mask_regs u_mask (
    .clk(clk), .rst_n(rst_n), .ack_take(ack_take), .mask_we(mask_we),
    .i_wdata(i_wdata), .ui_wdata(ui_wdata), .i_q(i_mask), .ui_q(ui_mask)
  );

  irq_prio_select #(.N_SRC(N_SRC), .ID_W(ID_W), .RANK_W(RANK_W)) u_sel (
    .req(req), .en_q(en_q), .lvl_q(lvl_q), .i_q(i_mask), .ui_q(ui_mask),
    .nmi(nmi), .addr_trap(addr_trap),
    .cand_valid(cand_valid), .cand_id(cand_id), .cand_rank(cand_rank),
    .sel_nmi(sel_nmi), .sel_trap(sel_trap), .sel_lvl1(sel_lvl1), .sel_lvl0(sel_lvl0)
  );

  irq_present #(.ID_W(ID_W), .RANK_W(RANK_W)) u_pres (
    .clk(clk), .rst_n(rst_n), .ack_take(ack_take),
    .cand_valid(cand_valid), .cand_id(cand_id), .cand_rank(cand_rank),
    .valid_q(irq_valid), .id_q(irq_id), .rank_q(held_rank)
  );

endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker #(
  parameter int ID_W   = 4,
  parameter int RANK_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              nmi,
  input logic              addr_trap,
  input logic              mask_we,
  input logic              i_wdata,
  input logic              ui_wdata,
  input logic              ack,
  input logic              irq_valid,
  input logic              i_mask,
  input logic              ui_mask,
  input logic              cand_valid,
  input logic [ID_W-1:0]   cand_id,
  input logic [RANK_W-1:0] held_rank,
  input logic              sel_nmi,
  input logic              sel_trap,
  input logic              sel_lvl1,
  input logic              sel_lvl0
);

  p_lvl0_needs_i_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_lvl0 |-> !i_mask);

  p_lvl1_needs_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_lvl1 |-> !(i_mask && ui_mask));

  p_nmi_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |-> (sel_nmi && cand_id == ID_W'(0)));

  p_trap_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_trap && !nmi) |-> (sel_trap && cand_id == ID_W'(1)));

  p_single_pick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_nmi, sel_trap, sel_lvl1, sel_lvl0}) &&
    (cand_valid == (sel_nmi || sel_trap || sel_lvl1 || sel_lvl0)));

  p_ack_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_valid) |=> (i_mask && ui_mask && !irq_valid));

  p_mask_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && !(ack && irq_valid)) |=>
      (i_mask == $past(i_wdata) && ui_mask == $past(ui_wdata)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !ack) |=> (irq_valid && held_rank <= $past(held_rank)));

endmodule

bind irq_mask_arbiter irq_arb_checker #(.ID_W(ID_W), .RANK_W(RANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .nmi(nmi), .addr_trap(addr_trap),
  .mask_we(mask_we), .i_wdata(i_wdata), .ui_wdata(ui_wdata), .ack(ack),
  .irq_valid(irq_valid), .i_mask(i_mask), .ui_mask(ui_mask),
  .cand_valid(cand_valid), .cand_id(cand_id), .held_rank(held_rank),
  .sel_nmi(sel_nmi), .sel_trap(sel_trap), .sel_lvl1(sel_lvl1), .sel_lvl0(sel_lvl0)
);

// File: tb/sim_irq_mask_arbiter.sv
module sim_irq_mask_arbiter;

  localparam int N    = 8;
  localparam int IDW  = $clog2(N + 2);
  localparam int WDOG = 5000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   req = '0, en_in = '0, lvl_in = '0;
  logic           nmi = 1'b0, addr_trap = 1'b0, cfg_we = 1'b0;
  logic           mask_we = 1'b0, i_wdata = 1'b0, ui_wdata = 1'b0, ack = 1'b0;
  logic           irq_valid, i_mask, ui_mask;
  logic [IDW-1:0] irq_id;

  always #4 clk = ~clk;  // 125 MHz

  irq_mask_arbiter #(.N_SRC(N)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .nmi(nmi), .addr_trap(addr_trap),
    .cfg_we(cfg_we), .en_in(en_in), .lvl_in(lvl_in), .mask_we(mask_we),
    .i_wdata(i_wdata), .ui_wdata(ui_wdata), .ack(ack),
    .irq_valid(irq_valid), .irq_id(irq_id), .i_mask(i_mask), .ui_mask(ui_mask)
  );

  typedef struct {
    string    tag;
    logic     v;
    int       id;
    logic     im;
    logic     uim;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  // Driver: inputs are already set; queue the expectation for the next edge.
  task automatic step(input string tag, input logic v, input int id,
                      input logic im, input logic uim);
    exp_t e;
    e.tag = tag; e.v = v; e.id = id; e.im = im; e.uim = uim;
    q.push_back(e);
    @(negedge clk);
    cfg_we  = 1'b0;
    mask_we = 1'b0;
    ack     = 1'b0;
  endtask

  task automatic wr_mask(input logic iv, input logic uv);
    mask_we = 1'b1; i_wdata = iv; ui_wdata = uv;
  endtask

  task automatic wr_cfg(input logic [N-1:0] e, input logic [N-1:0] l);
    cfg_we = 1'b1; en_in = e; lvl_in = l;
  endtask

  // Monitor: compare after each edge.
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      bit bad;
      e = q.pop_front();
      checks++;
      bad = (irq_valid !== e.v) || (i_mask !== e.im) || (ui_mask !== e.uim) ||
            (e.v && (int'(irq_id) != e.id));
      if (bad) begin
        failures++;
        $display("FAIL %s: valid=%0d id=%0d I=%0d UI=%0d expected valid=%0d id=%0d I=%0d UI=%0d",
                 e.tag, irq_valid, irq_id, i_mask, ui_mask, e.v, e.id, e.im, e.uim);
      end
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step("R1 reset state", 0, 0, 1, 1);
    req = '1; wr_mask(0, 0);
    step("R8 mask write opens", 0, 0, 0, 0);
    step("R1 enables reset to zero", 0, 0, 0, 0);
    wr_cfg(8'b0000_0100, 8'b0000_0000);
    step("R11 cfg not yet active", 0, 0, 0, 0);
    step("R4 only enabled source 2", 1, 4, 0, 0);
    ack = 1'b1;
    step("R7 ack closes masks", 0, 0, 1, 1);
    step("R2 level0 blocked I=1", 0, 0, 1, 1);
    wr_mask(1, 0);
    step("R8 write I=1 UI=0", 0, 0, 1, 0);
    step("R2 level0 blocked with UI=0", 0, 0, 1, 0);
    wr_cfg(8'b0010_0100, 8'b0010_0000);
    step("R11 level cfg write", 0, 0, 1, 0);
    step("R3 level1 open with UI=0", 1, 7, 1, 0);
    ack = 1'b1; wr_mask(0, 0);
    step("R7 ack beats mask write", 0, 0, 1, 1);
    step("R3 level1 blocked I=UI=1", 0, 0, 1, 1);
    addr_trap = 1'b1;
    step("R5 trap through closed masks", 1, 1, 1, 1);
    nmi = 1'b1;
    step("R9 nmi preempts held trap", 1, 0, 1, 1);
    ack = 1'b1; nmi = 1'b0; addr_trap = 1'b0;
    step("R7 ack after nmi", 0, 0, 1, 1);
    wr_mask(0, 1);
    step("R8 write I=0 UI=1", 0, 0, 0, 1);
    step("R6 level1 src5 beats level0 src2", 1, 7, 0, 1);
    wr_cfg(8'b0010_0100, 8'b0000_0000);
    step("R9 hold during cfg change", 1, 7, 0, 1);
    step("R9 lower rank does not preempt", 1, 7, 0, 1);
    ack = 1'b1;
    step("R7 ack closes again", 0, 0, 1, 1);
    wr_mask(0, 0);
    step("R8 reopen", 0, 0, 0, 0);
    step("R6 lower index wins in level0", 1, 4, 0, 0);
    req = 8'b0010_0000;
    step("R9 hold after withdraw", 1, 4, 0, 0);
    ack = 1'b1; req = '0;
    step("R7 ack src2", 0, 0, 1, 1);
    wr_mask(0, 0);
    step("R8 reopen again", 0, 0, 0, 0);
    ack = 1'b1;
    step("R7 idle ack ignored", 0, 0, 0, 0);
    addr_trap = 1'b1; req = 8'b0010_0000;
    step("R5 trap over maskable", 1, 1, 0, 0);
    ack = 1'b1; addr_trap = 1'b0; req = '0;
    step("R10 ack trap then idle", 0, 0, 1, 1);
    step("R10 idle stays low", 0, 0, 1, 1);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule